// File: doc/BRIEF.md
# Dual-Role Serial Byte Port with Early-Deselect Detection

This block is an 8-bit serial port that works either as the clock-driving end or as the clock-following end of a four-wire synchronous link. A 3-bit field in its control register selects the role. For the driving role, the same field also selects the clock source: one of three system-clock dividers, a slow auxiliary clock, or half the rate of a one-cycle timer-match pulse. Software reaches the block through a byte-wide register port with three addresses: control, data and status. An interrupt line mirrors the transfer-done flag when interrupts are enabled.

In the following role the port takes its clock and its select line from outside. Both pass through a two-flop synchronizer. If the far end deselects the port before a whole byte has moved, the port records an incomplete transfer. It raises that flag and the done flag in the same cycle, so that software learns of the aborted byte through the usual done path. The link runs in a single fixed clock mode: the clock idles low, data is sampled on the rising edge, data changes on the falling edge, and the MSB goes first.

The controller is built around one state machine. Its states are `ST_OFF`, `ST_IDLE`, `ST_M_LOW`, `ST_M_HIGH` and `ST_SLAVE`, and it moves between them as follows:
- Any state goes to `ST_OFF` when the port is disabled.
- `ST_OFF` goes to `ST_SLAVE` or to `ST_IDLE`, depending on the role.
- `ST_IDLE` goes to `ST_SLAVE` when the following role is chosen.
- `ST_IDLE` goes to `ST_M_LOW` on a data write.
- `ST_M_LOW` goes to `ST_M_HIGH` on a clock tick.
- `ST_M_HIGH` goes to `ST_M_LOW` on a tick, or to `ST_IDLE` on the tick that ends the eighth bit.
- `ST_SLAVE` goes to `ST_IDLE` when the driving role is chosen.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset the control register (address 0) reads 0xE0, the status register (address 2) reads 0x00, `irq` is 0, and neither `sck_oe` nor `sdo_oe` is asserted.
- R2: Control bits 4..2 always read as 0, whatever value was written to them.
- R3: Control bits 7..5 set to 000, 001 or 010 make the port drive SCK with a period of 4, 16 or 64 system clocks. SCK idles low while no transfer runs.
- R4: Mode 011 toggles SCK on each edge of `sub_clk_i`. Mode 100 toggles SCK on each one-cycle `tmr_match_i` pulse, which gives half the pulse rate.
- R5: In a driving mode with enable set (control bit 1), a data-register write (address 1) while idle sends that byte MSB first. SDO changes only on falling SCK and SDI is sampled on rising SCK. The received byte then reads back at address 1, status bit 0 (done) is set, and `irq` equals done AND status bit 7 (interrupt enable).
- R6: A data write while a driving transfer is in progress does not alter the byte being sent and sets status bit 1 (write collision).
- R7: In mode 101 (following role) the port shifts a byte clocked in from `sck_i` while selected. It drives the preloaded byte out on `sdo_o` MSB first, leaves the received byte at address 1, and sets done after the eighth falling edge.
- R8: In mode 101, with enable set and select-enable set (status bit 6), a rise of `scs_i` in the middle of a byte sets control bit 0 (incomplete) and done together.
- R9: Software writing 1 to control bit 0 sets the incomplete flag but leaves done clear.
- R10: With enable clear, or with mode 110/111, the port drives no pin and a data write starts no transfer.
- R11: Done, incomplete and collision flags stay set until software writes 0 to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| sub_clk_i | input | 1 | Slow auxiliary clock level |
| tmr_match_i | input | 1 | One-cycle timer match pulse |
| sck_i | input | 1 | Serial clock from the far end (following role) |
| sck_o | output | 1 | Serial clock driven (driving role) |
| sck_oe | output | 1 | Output enable for `sck_o` |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo_o` |
| scs_i | input | 1 | Active-low select from the far end |

## Verification
The bench measures the SCK period for every clock source. A divider that is off by one, or a timer path that ticks on both pulse edges, shows up as a wrong period. It cuts a following-role byte short after three bits and expects incomplete and done to rise together. A design that only resets its bit counter would leave both flags clear. It writes the incomplete flag from software and expects done to stay low, which catches a design that shares one set path for both flags. It also writes data in the middle of a transfer and checks that the far end still received the first byte, so a design that reloads its shifter would corrupt the byte on the wire.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_SLAVE
    } xfer_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [2:0] MODE_DIV_A  = 3'b000;
    localparam logic [2:0] MODE_DIV_B  = 3'b001;
    localparam logic [2:0] MODE_DIV_C  = 3'b010;
    localparam logic [2:0] MODE_SUBCLK = 3'b011;
    localparam logic [2:0] MODE_TIMER  = 3'b100;
    localparam logic [2:0] MODE_FOLLOW = 3'b101;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
    import spi_port_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] mode,
    input  logic       sub_lvl,
    input  logic       tmr_pulse,
    output logic       tick
);

    localparam int HALF_A = DIV_A / 2;
    localparam int HALF_B = DIV_B / 2;
    localparam int HALF_C = DIV_C / 2;
    localparam int CW     = (HALF_C > 1) ? $clog2(HALF_C) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          sub_prev_q;
    logic          div_mode;

    always_comb begin
        div_mode = 1'b1;
        unique case (mode)
            MODE_DIV_A: limit = CW'(HALF_A - 1);
            MODE_DIV_B: limit = CW'(HALF_B - 1);
            MODE_DIV_C: limit = CW'(HALF_C - 1);
            default: begin
                limit    = '0;
                div_mode = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sub_prev_q <= 1'b0;
        end else begin
            sub_prev_q <= sub_lvl;
            if (!run || !div_mode || cnt_q == limit) cnt_q <= '0;
            else                                     cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (run) begin
            if (div_mode)                 tick = (cnt_q == limit);
            else if (mode == MODE_SUBCLK) tick = (sub_lvl != sub_prev_q);
            else if (mode == MODE_TIMER)  tick = tmr_pulse;
        end
    end

endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
    import spi_port_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          sub_clk_i,
    input  logic          tmr_match_i,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sdi_i,
    output logic          sdo_o,
    output logic          sdo_oe,
    input  logic          scs_i
);

    localparam int            BCW  = $clog2(DW);
    localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

    xfer_state_t    state_q, state_d;
    logic [2:0]     mode_q;
    logic           en_q, icf_q, done_q, wcol_q, csen_q, irqen_q;
    logic [DW-1:0]  shreg_q;
    logic           samp_q, seen_rise_q;
    logic [BCW-1:0] bitcnt_q;
    logic           s_sub, s_scs, s_sck, sck_d_q, scs_d_q;
    logic           tick;
    logic           unused_wbits;

    assign unused_wbits = ^reg_wdata[4:2];

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sub_clk_i, scs_i, sck_i}),
        .q    ({s_sub, s_scs, s_sck})
    );

    // decoded controls
    logic port_on, is_follow, m_busy, selected;
    logic sck_rise, sck_fall, scs_rise;
    logic wr_ctrl, wr_data, wr_stat;
    logic f_busy, m_last, f_last, hw_icf;

    assign port_on   = en_q && (mode_q[2:1] != 2'b11);
    assign is_follow = (mode_q == MODE_FOLLOW);
    assign m_busy    = (state_q == ST_M_LOW) || (state_q == ST_M_HIGH);
    assign selected  = !csen_q || !s_scs;
    assign sck_rise  = s_sck && !sck_d_q;
    assign sck_fall  = !s_sck && sck_d_q;
    assign scs_rise  = s_scs && !scs_d_q;
    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign f_busy    = (state_q == ST_SLAVE) && ((bitcnt_q != '0) || seen_rise_q);
    assign m_last    = (state_q == ST_M_HIGH) && tick && (bitcnt_q == LAST);
    assign f_last    = (state_q == ST_SLAVE) && selected && !(csen_q && s_scs)
                       && sck_fall && seen_rise_q && (bitcnt_q == LAST);
    assign hw_icf    = (state_q == ST_SLAVE) && en_q && csen_q && scs_rise
                       && ((bitcnt_q != '0) || seen_rise_q);

    spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (m_busy),
        .mode     (mode_q),
        .sub_lvl  (s_sub),
        .tmr_pulse(tmr_match_i),
        .tick     (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!port_on) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = is_follow ? ST_SLAVE : ST_IDLE;
                ST_IDLE:   begin
                    if (is_follow)    state_d = ST_SLAVE;
                    else if (wr_data) state_d = ST_M_LOW;
                end
                ST_M_LOW:  if (tick) state_d = ST_M_HIGH;
                ST_M_HIGH: if (tick) state_d = (bitcnt_q == LAST) ? ST_IDLE : ST_M_LOW;
                ST_SLAVE:  if (!is_follow) state_d = ST_IDLE;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // registers, shifter and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= 3'b111;
            en_q        <= 1'b0;
            icf_q       <= 1'b0;
            done_q      <= 1'b0;
            wcol_q      <= 1'b0;
            csen_q      <= 1'b0;
            irqen_q     <= 1'b0;
            shreg_q     <= '0;
            samp_q      <= 1'b0;
            seen_rise_q <= 1'b0;
            bitcnt_q    <= '0;
            sck_d_q     <= 1'b0;
            scs_d_q     <= 1'b1;
        end else begin
            sck_d_q <= s_sck;
            scs_d_q <= s_scs;

            if (wr_ctrl) begin
                mode_q <= reg_wdata[7:5];
                en_q   <= reg_wdata[1];
            end
            if (wr_stat) begin
                irqen_q <= reg_wdata[7];
                csen_q  <= reg_wdata[6];
            end

            if (hw_icf)       icf_q <= 1'b1;
            else if (wr_ctrl) icf_q <= reg_wdata[0];

            if (m_last || f_last || hw_icf) done_q <= 1'b1;
            else if (wr_stat)               done_q <= reg_wdata[0];

            if (wr_data && m_busy) wcol_q <= 1'b1;
            else if (wr_stat)      wcol_q <= reg_wdata[1];

            if (wr_data && !m_busy && !f_busy) begin
                shreg_q  <= reg_wdata;
                bitcnt_q <= '0;
            end

            unique case (state_q)
                ST_OFF: begin
                    bitcnt_q    <= '0;
                    seen_rise_q <= 1'b0;
                end
                ST_M_LOW: if (tick) samp_q <= sdi_i;
                ST_M_HIGH: if (tick) begin
                    shreg_q  <= {shreg_q[DW-2:0], samp_q};
                    bitcnt_q <= (bitcnt_q == LAST) ? '0 : bitcnt_q + 1'b1;
                end
                ST_SLAVE: begin
                    if (csen_q && s_scs) begin
                        bitcnt_q    <= '0;
                        seen_rise_q <= 1'b0;
                    end else if (selected) begin
                        if (sck_rise) begin
                            samp_q      <= sdi_i;
                            seen_rise_q <= 1'b1;
                        end else if (sck_fall && seen_rise_q) begin
                            shreg_q     <= {shreg_q[DW-2:0], samp_q};
                            seen_rise_q <= 1'b0;
                            bitcnt_q    <= (bitcnt_q == LAST) ? '0 : bitcnt_q + 1'b1;
                        end
                    end
                end
                default: seen_rise_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck_oe = port_on && ((state_q == ST_IDLE) || m_busy);
        sck_o  = port_on && (state_q == ST_M_HIGH);
        sdo_oe = port_on && (((state_q == ST_IDLE) || m_busy)
                 || ((state_q == ST_SLAVE) && selected));
        sdo_o  = shreg_q[DW-1];
        irq    = done_q && irqen_q;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = DW'({mode_q, 3'b000, en_q, icf_q});
            ADDR_DATA: reg_rdata = shreg_q;
            ADDR_STAT: reg_rdata = DW'({irqen_q, csen_q, 4'b0000, wcol_q, done_q});
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_duplex_port_sva.sv
module spi_duplex_port_sva #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_rdata,
    input logic          sck_o,
    input logic          sck_oe,
    input logic          sdo_oe,
    input logic          en_q,
    input logic          icf_q,
    input logic          done_q,
    input logic          wcol_q,
    input logic          m_busy
);

    // R2
    a_r2_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[4:2] == 3'b000));

    // R3
    a_r3_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !m_busy |-> !sck_o);

    // R6
    a_r6_busy_write_collides: assert property (@(posedge clk) disable iff (!rst_n)
        (m_busy && reg_wr && reg_addr == 2'd1) |=> wcol_q);

    // R8
    a_r8_icf_brings_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(icf_q) && !$past(reg_wr && reg_addr == 2'd0)) |-> done_q);

    // R10
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!sck_oe && !sdo_oe));

    // R11
    a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(reg_wr && reg_addr == 2'd2)) |=> done_q);

    a_r11_icf_held: assert property (@(posedge clk) disable iff (!rst_n)
        (icf_q && !(reg_wr && reg_addr == 2'd0)) |=> icf_q);

    a_r11_wcol_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_q && !(reg_wr && reg_addr == 2'd2)) |=> wcol_q);

endmodule

bind spi_duplex_port spi_duplex_port_sva #(.DW(DW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rdata(reg_rdata),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe),
    .sdo_oe   (sdo_oe),
    .en_q     (en_q),
    .icf_q    (icf_q),
    .done_q   (done_q),
    .wcol_q   (wcol_q),
    .m_busy   (m_busy)
);

// File: tb/spi_duplex_port_bench.sv
`timescale 1ns/1ps
module spi_duplex_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sub_clk_i = 1'b0;
    logic       tmr_match_i = 1'b0;
    logic       sck_b = 1'b0;
    logic       sck_o, sck_oe;
    logic       sdi_i;
    logic       sdo_o, sdo_oe;
    logic       scs_b = 1'b1;
    logic       sdi_b = 1'b0;
    logic       follow_test = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // far-end model for driving-role tests
    logic [7:0] fe_tx = '0;
    logic [7:0] fe_rx = '0;
    realtime    last_rise = 0.0;
    realtime    sck_per = 0.0;
    logic       sub_run = 1'b0;
    logic       tmr_run = 1'b0;

    always #10 clk = ~clk;

    assign sdi_i = follow_test ? sdi_b : fe_tx[7];

    spi_duplex_port u_spi_duplex_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .sub_clk_i  (sub_clk_i),
        .tmr_match_i(tmr_match_i),
        .sck_i      (sck_b),
        .sck_o      (sck_o),
        .sck_oe     (sck_oe),
        .sdi_i      (sdi_i),
        .sdo_o      (sdo_o),
        .sdo_oe     (sdo_oe),
        .scs_i      (scs_b)
    );

    always @(posedge sck_o) begin
        if (sck_oe) begin
            fe_rx = {fe_rx[6:0], sdo_o};
            if (last_rise > 0.0) sck_per = $realtime - last_rise;
            last_rise = $realtime;
        end
    end

    always @(negedge sck_o) begin
        if (sck_oe) fe_tx = {fe_tx[6:0], 1'b0};
    end

    initial begin
        forever begin
            @(negedge clk);
            if (sub_run) begin
                repeat (4) @(negedge clk);
                sub_clk_i = ~sub_clk_i;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            tmr_match_i = 1'b0;
            if (tmr_run) begin
                repeat (2) @(negedge clk);
                tmr_match_i = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input int limit);
        logic [7:0] s;
        for (int i = 0; i < limit; i++) begin
            rd(2'd2, s);
            if (s[0]) break;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 8'hE0);
        rd(2'd2, v); chk("R1 status", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 oe", {sck_oe, sdo_oe}, 0);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R2 pad bits", v, 8'hE3);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_master(input logic [2:0] mode, input logic [7:0] tx,
                            input logic [7:0] far, input int period);
        logic [7:0] v;
        wr(2'd2, 8'h80);
        wr(2'd0, {mode, 5'b00010});
        fe_tx = far; fe_rx = '0; last_rise = 0.0; sck_per = 0.0;
        wr(2'd1, tx);
        wait_done(2000);
        chk("R5 far end got byte", fe_rx, tx);
        rd(2'd1, v); chk("R5 received byte", v, far);
        rd(2'd2, v); chk("R5 done", v[0], 1);
        chk("R5 irq", irq, 1);
        chk(mode < 3 ? "R3 sck period" : "R4 sck period",
            int'(sck_per / 20.0), period);
        chk("R3 sck idle low", sck_o, 0);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R11 done held", v[0], 1);
        wr(2'd2, 8'h00);
        chk("R5 irq drops", irq, 0);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        wr(2'd0, 8'h22);
        fe_tx = 8'h00; fe_rx = '0;
        wr(2'd1, 8'hC3);
        repeat (10) @(negedge clk);
        wr(2'd1, 8'h18);
        wait_done(2000);
        chk("R6 byte unaltered", fe_rx, 8'hC3);
        rd(2'd2, v); chk("R6 collision", v[1], 1);
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R11 collision held", v[1], 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R11 collision cleared", v[1], 0);
    endtask

    task automatic f_bits(input logic [7:0] tx, input int nbits, output logic [7:0] seen);
        seen = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi_b = tx[7 - i];
            repeat (6) @(negedge clk);
            seen = {seen[6:0], sdo_o};
            sck_b = 1'b1;
            repeat (6) @(negedge clk);
            sck_b = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_follow;
        logic [7:0] v, seen;
        follow_test = 1'b1;
        wr(2'd2, 8'h40);
        wr(2'd0, 8'hA2);
        wr(2'd1, 8'h6D);
        scs_b = 1'b0;
        repeat (6) @(negedge clk);
        f_bits(8'hB4, 8, seen);
        scs_b = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 sdo byte", seen, 8'h6D);
        rd(2'd1, v); chk("R7 received", v, 8'hB4);
        rd(2'd2, v); chk("R7 done", v[0], 1);
        rd(2'd0, v); chk("R7 no incomplete", v[0], 0);
        wr(2'd2, 8'h40);
        // cut short after three bits
        scs_b = 1'b0;
        repeat (6) @(negedge clk);
        f_bits(8'hE0, 3, seen);
        scs_b = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R8 incomplete", v, 8'hA3);
        rd(2'd2, v); chk("R8 done", v[0], 1);
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R11 incomplete held", v[0], 1);
        wr(2'd2, 8'h40);
        wr(2'd0, 8'hA2);
        wr(2'd0, 8'hA3);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R9 sw incomplete set", v[0], 1);
        rd(2'd2, v); chk("R9 done stays clear", v[0], 0);
        wr(2'd0, 8'hA2);
        follow_test = 1'b0;
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h5A);
        repeat (100) @(negedge clk);
        chk("R10 no drive (en=0)", {sck_oe, sdo_oe}, 0);
        rd(2'd2, v); chk("R10 no done (en=0)", v[0], 0);
        wr(2'd0, 8'hC2);
        wr(2'd1, 8'h5A);
        repeat (100) @(negedge clk);
        chk("R10 no drive (mode 110)", {sck_oe, sdo_oe}, 0);
        rd(2'd2, v); chk("R10 no done (mode 110)", v[0], 0);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_master(3'b000, 8'hA5, 8'h3C, 4);
        t_master(3'b001, 8'h81, 8'hF0, 16);
        t_master(3'b010, 8'h0F, 8'h99, 64);
        sub_run = 1'b1;
        t_master(3'b011, 8'h5E, 8'h27, 10);
        sub_run = 1'b0;
        tmr_run = 1'b1;
        t_master(3'b100, 8'hC6, 8'h41, 6);
        tmr_run = 1'b0;
        t_collision();
        t_follow();
        t_disabled();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule